// File: doc/BRIEF.md
# Reset Boot Load Sequencer

After reset, this block brings a processor up from one of three external boot sources: a parallel EPROM port, an SPI port in master mode or an SPI port in slave mode. The sequencer reads a two-bit strap once, on the first clock after reset is released. It then copies a loader kernel of fixed length, word by word, from the chosen source into internal memory through a single write port. Each source reaches the block as a plain word stream with valid and ready.

When the last kernel word has been written, the sequencer raises the interrupt of the peripheral it booted from. It also presents that peripheral's vector as the core's fetch address. The core acknowledges the interrupt and runs the kernel. When the kernel signals that it has finished, the sequencer switches the fetch address to the normal program start and stays there until the next reset. A reserved strap code raises an error flag and leaves the sequencer idle.

Top module: `boot_load_sequencer`

## Requirements
- R1: The strap is captured on the first clock edge after reset is released. Later changes on `boot_strap` have no effect on the source, the vector or the error flag until the next reset.
- R2: Strap code 2'b00 selects the parallel port, 2'b01 selects SPI slave and 2'b10 selects SPI master. Code 2'b11 sets `strap_err` from the second clock after release. With code 2'b11, no ready, write, interrupt or `fetch_valid` is ever asserted.
- R3: While the kernel is loading, only the selected source's ready is high. The other sources' ready stays low, and their valid and data never reach the write port.
- R4: `mem_we` is high exactly in cycles where the selected source has valid and ready both high. In such a cycle, `mem_addr` is 0x80000 plus the word index and `mem_wdata` is that word.
- R5: Exactly 256 words of 32 bits are written. From the cycle after the 256th write, every ready is low and a held valid causes no write.
- R6: In the cycle after the 256th write, the booted peripheral's interrupt is high: `irq_par` for the parallel port, and `irq_spi` for either SPI mode. At the same time `fetch_valid` is high and `fetch_addr` is 0x80050 for the parallel port or 0x80030 for SPI.
- R7: The interrupt stays high until a cycle with `irq_ack` high, and is low from the next cycle on. An `irq_ack` given before the interrupt rises has no effect.
- R8: After the acknowledge, `fetch_addr` keeps the vector until a rising edge of `kernel_done`. From the next cycle on, `fetch_addr` is 0x80005. A `kernel_done` pulse that arrives before the acknowledge is ignored. A `kernel_done` that is already high when the acknowledge takes effect does not advance the sequencer.
- R9: While reset is high, every ready, `mem_we`, both interrupts, `fetch_valid` and `strap_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 2 | Boot source strap |
| par_valid | input | 1 | Parallel source word valid |
| par_data | input | 32 | Parallel source word |
| par_ready | output | 1 | Parallel source may deliver |
| spis_valid | input | 1 | SPI-slave source word valid |
| spis_data | input | 32 | SPI-slave source word |
| spis_ready | output | 1 | SPI-slave source may deliver |
| spim_valid | input | 1 | SPI-master source word valid |
| spim_data | input | 32 | SPI-master source word |
| spim_ready | output | 1 | SPI-master source may deliver |
| mem_we | output | 1 | Internal memory write enable |
| mem_addr | output | 20 | Internal memory write address |
| mem_wdata | output | 32 | Internal memory write data |
| irq_ack | input | 1 | Core acknowledges the boot interrupt |
| irq_par | output | 1 | Parallel port boot interrupt |
| irq_spi | output | 1 | SPI boot interrupt |
| kernel_done | input | 1 | Loader kernel has finished |
| fetch_valid | output | 1 | Fetch address is meaningful |
| fetch_addr | output | 20 | First fetch address for the core |
| strap_err | output | 1 | Reserved strap code was captured |

## Verification
A wrong captured strap shows within two cycles of reset release, as the wrong source's ready going high. If the strap is re-captured, the fault shows later, as a wrong vector after the load. A word counter that is off appears on the first write as a shifted `mem_addr`. An early or late end of the load appears as an interrupt rising before or after the 256th handshake, or as a write after it. A state machine stuck in the wrong phase shows at once, as an interrupt that drops without an acknowledge or a `fetch_addr` that moves to 0x80005 without a fresh `kernel_done` edge.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam int ADDR_W       = 20;
    localparam int DATA_W       = 32;
    localparam int KERNEL_WORDS = 256;
    localparam int NUM_SRC      = 3;

    localparam logic [ADDR_W-1:0] KERNEL_BASE = 20'h80000;
    localparam logic [ADDR_W-1:0] VEC_SPI     = 20'h80030;
    localparam logic [ADDR_W-1:0] VEC_PAR     = 20'h80050;
    localparam logic [ADDR_W-1:0] RUN_ADDR    = 20'h80005;

    // Strap code values; the value doubles as the source index.
    typedef enum logic [1:0] {
        SRC_PAR     = 2'b00,
        SRC_SPI_SLV = 2'b01,
        SRC_SPI_MST = 2'b10,
        SRC_RSVD    = 2'b11
    } boot_src_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STRAP,
        S_LOAD,
        S_IRQ,
        S_KERNEL,
        S_RUN
    } seq_state_e;

    typedef struct packed {
        logic      captured;
        logic      reserved;
        boot_src_e src;
    } strap_info_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_wr_t;

    function automatic logic src_is_spi(boot_src_e s);
        return (s == SRC_SPI_SLV) || (s == SRC_SPI_MST);
    endfunction

    function automatic logic [ADDR_W-1:0] vector_for(boot_src_e s);
        return src_is_spi(s) ? VEC_SPI : VEC_PAR;
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_en,
    input  logic [1:0]  strap_pins,
    output strap_info_t info
);

    always_ff @(posedge clk) begin
        if (rst) begin
            info <= '{captured: 1'b0, reserved: 1'b0, src: SRC_PAR};
        end else if (sample_en && !info.captured) begin
            info <= '{captured: 1'b1,
                      reserved: (strap_pins == SRC_RSVD),
                      src:      boot_src_e'(strap_pins)};
        end
    end

endmodule

// File: rtl/boot_word_mover.sv
module boot_word_mover
    import boot_seq_pkg::*;
#(
    parameter int WORD_W = DATA_W,
    parameter int N_WORDS = KERNEL_WORDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  boot_src_e           src,
    input  logic [NUM_SRC-1:0]  src_valid,
    input  logic [WORD_W-1:0]   src_data [NUM_SRC],
    output logic [NUM_SRC-1:0]  src_ready,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WORD_W-1:0]   wr_data,
    output logic                last_beat
);

    localparam int CNT_W = $clog2(N_WORDS) + 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_WORDS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_WORDS);

    logic [CNT_W-1:0] count_q;
    logic             room;
    logic             beat;

    assign room = active && (count_q < FULL_CNT);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ready
        assign src_ready[g] = room && (int'(src) == g);
    end

    always_comb begin
        wr_data = '0;
        for (int g = 0; g < NUM_SRC; g++) begin
            if (int'(src) == g) wr_data = src_data[g];
        end
    end

    assign beat      = |(src_valid & src_ready);
    assign wr_en     = beat;
    assign wr_addr   = KERNEL_BASE + ADDR_W'(count_q);
    assign last_beat = beat && (count_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (beat) begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/boot_irq_ctrl.sv
module boot_irq_ctrl
    import boot_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raise,
    input  boot_src_e src,
    input  logic      ack,
    output logic      irq_par,
    output logic      irq_spi,
    output logic      pending
);

    logic spi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            spi_q   <= 1'b0;
        end else if (raise) begin
            pending <= 1'b1;
            spi_q   <= src_is_spi(src);
        end else if (pending && ack) begin
            pending <= 1'b0;
        end
    end

    assign irq_par = pending && !spi_q;
    assign irq_spi = pending && spi_q;

endmodule

// File: rtl/boot_load_sequencer.sv
module boot_load_sequencer
    import boot_seq_pkg::*;
#(
    parameter int WORD_W  = DATA_W,
    parameter int N_WORDS = KERNEL_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        boot_strap,
    input  logic              par_valid,
    input  logic [WORD_W-1:0] par_data,
    output logic              par_ready,
    input  logic              spis_valid,
    input  logic [WORD_W-1:0] spis_data,
    output logic              spis_ready,
    input  logic              spim_valid,
    input  logic [WORD_W-1:0] spim_data,
    output logic              spim_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              irq_ack,
    output logic              irq_par,
    output logic              irq_spi,
    input  logic              kernel_done,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              strap_err
);

    seq_state_e  state_q, state_d;
    strap_info_t strap;
    logic        last_beat;
    logic        irq_pending;
    logic        done_q;
    logic        done_edge;

    logic [NUM_SRC-1:0] valid_vec;
    logic [NUM_SRC-1:0] ready_vec;
    logic [WORD_W-1:0]  data_arr [NUM_SRC];

    assign valid_vec = {spim_valid, spis_valid, par_valid};
    assign data_arr[SRC_PAR]     = par_data;
    assign data_arr[SRC_SPI_SLV] = spis_data;
    assign data_arr[SRC_SPI_MST] = spim_data;
    assign par_ready  = ready_vec[SRC_PAR];
    assign spis_ready = ready_vec[SRC_SPI_SLV];
    assign spim_ready = ready_vec[SRC_SPI_MST];

    boot_strap_latch i_strap (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (state_q == S_IDLE),
        .strap_pins (boot_strap),
        .info       (strap)
    );

    boot_word_mover #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) i_mover (
        .clk       (clk),
        .rst       (rst),
        .active    (state_q == S_LOAD),
        .src       (strap.src),
        .src_valid (valid_vec),
        .src_data  (data_arr),
        .src_ready (ready_vec),
        .wr_en     (mem_we),
        .wr_addr   (mem_addr),
        .wr_data   (mem_wdata),
        .last_beat (last_beat)
    );

    boot_irq_ctrl i_irq (
        .clk     (clk),
        .rst     (rst),
        .raise   (last_beat),
        .src     (strap.src),
        .ack     (irq_ack),
        .irq_par (irq_par),
        .irq_spi (irq_spi),
        .pending (irq_pending)
    );

    // Only a fresh rising edge of kernel_done counts.
    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= kernel_done;
    end
    assign done_edge = kernel_done && !done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (!strap.captured) state_d = S_STRAP;
            S_STRAP:  state_d = strap.reserved ? S_IDLE : S_LOAD;
            S_LOAD:   if (last_beat) state_d = S_IRQ;
            S_IRQ:    if (irq_pending && irq_ack) state_d = S_KERNEL;
            S_KERNEL: if (done_edge) state_d = S_RUN;
            S_RUN:    state_d = S_RUN;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        fetch_valid = 1'b0;
        fetch_addr  = '0;
        unique case (state_q)
            S_IRQ, S_KERNEL: begin
                fetch_valid = 1'b1;
                fetch_addr  = vector_for(strap.src);
            end
            S_RUN: begin
                fetch_valid = 1'b1;
                fetch_addr  = RUN_ADDR;
            end
            default: ;
        endcase
    end

    assign strap_err = strap.captured && strap.reserved;

endmodule

// File: rtl/boot_load_sequencer_chk.sv
module boot_load_sequencer_chk
    import boot_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              par_valid,
    input logic              par_ready,
    input logic              spis_valid,
    input logic              spis_ready,
    input logic              spim_valid,
    input logic              spim_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              irq_ack,
    input logic              irq_par,
    input logic              irq_spi,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              strap_err
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = KERNEL_BASE + ADDR_W'(KERNEL_WORDS - 1);

    a_r3_single_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0({par_ready, spis_ready, spim_ready}));

    a_r4_write_needs_handshake: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((par_valid && par_ready) || (spis_valid && spis_ready) ||
                    (spim_valid && spim_ready)));

    a_r5_addr_in_window: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr >= KERNEL_BASE && mem_addr <= TOP_ADDR));

    a_r6_one_irq: assert property (@(posedge clk) disable iff (rst)
        !(irq_par && irq_spi));

    a_r7_par_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq_par && !irq_ack) |=> irq_par);

    a_r7_spi_irq_held: assert property (@(posedge clk) disable iff (rst)
        (irq_spi && !irq_ack) |=> irq_spi);

    a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr == RUN_ADDR) |=> (fetch_valid && fetch_addr == RUN_ADDR));

    a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
        strap_err |-> (!fetch_valid && !mem_we && !par_ready && !spis_ready && !spim_ready));

    a_r1_err_sticky: assert property (@(posedge clk) disable iff (rst)
        strap_err |=> strap_err);

endmodule

bind boot_load_sequencer boot_load_sequencer_chk i_chk (.*);

// File: tb/test_boot_load_sequencer.sv
module test_boot_load_sequencer;
    import boot_seq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [1:0]  strap;
        logic [1:0]  later;
        logic        err;
        logic        spi;
        logic [19:0] vec;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{strap: 2'b00, later: 2'b10, err: 1'b0, spi: 1'b0, vec: 20'h80050},
        '{strap: 2'b01, later: 2'b00, err: 1'b0, spi: 1'b1, vec: 20'h80030},
        '{strap: 2'b10, later: 2'b11, err: 1'b0, spi: 1'b1, vec: 20'h80030},
        '{strap: 2'b11, later: 2'b00, err: 1'b1, spi: 1'b0, vec: 20'h00000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_strap = 2'b00;
    logic [2:0]  b_valid = '0;
    logic [31:0] b_data [3];
    logic [2:0]  b_ready;
    logic        mem_we;
    logic [19:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        irq_ack = 1'b0;
    logic        irq_par, irq_spi;
    logic        kernel_done = 1'b0;
    logic        fetch_valid;
    logic [19:0] fetch_addr;
    logic        strap_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_load_sequencer i_boot_load_sequencer (
        .clk         (clk),
        .rst         (rst),
        .boot_strap  (boot_strap),
        .par_valid   (b_valid[0]),
        .par_data    (b_data[0]),
        .par_ready   (b_ready[0]),
        .spis_valid  (b_valid[1]),
        .spis_data   (b_data[1]),
        .spis_ready  (b_ready[1]),
        .spim_valid  (b_valid[2]),
        .spim_data   (b_data[2]),
        .spim_ready  (b_ready[2]),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .irq_ack     (irq_ack),
        .irq_par     (irq_par),
        .irq_spi     (irq_spi),
        .kernel_done (kernel_done),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .strap_err   (strap_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int src, input int k);
        return (32'(k) * 32'h0100_0193) ^ 32'hC0DE_0000 ^ 32'(src);
    endfunction

    task automatic do_reset(input logic [1:0] s);
        rst = 1'b1;
        boot_strap = s;
        b_valid = '0;
        irq_ack = 1'b0;
        kernel_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R9: quiet outputs while reset is held
        chk(b_ready == 3'b000 && !mem_we && !irq_par && !irq_spi && !fetch_valid && !strap_err,
            "R9 reset state", {b_ready, mem_we, irq_par, irq_spi, fetch_valid, strap_err}, 0);
        rst = 1'b0;
    endtask

    task automatic run_row(input row_t r, input bit hold_done);
        int sel;
        int errs;
        logic [2:0] exp_ready;
        sel = int'(r.strap);
        do_reset(r.strap);
        @(posedge clk);
        #1 boot_strap = r.later;        // R1: change after the capture edge
        @(posedge clk);
        @(negedge clk);
        #1;
        if (r.err) begin
            chk(strap_err == 1'b1, "R2 reserved code flags error", strap_err, 1);
            b_valid = 3'b111;
            repeat (12) @(posedge clk);
            @(negedge clk);
            #1;
            chk(b_ready == 3'b000 && !mem_we && !irq_par && !irq_spi && !fetch_valid,
                "R2 reserved code stays idle",
                {b_ready, mem_we, irq_par, irq_spi, fetch_valid}, 0);
            return;
        end
        exp_ready = 3'b001 << sel;
        chk(b_ready == exp_ready, "R3 only selected source ready", b_ready, exp_ready);
        chk(strap_err == 1'b0, "R2 valid code has no error", strap_err, 0);
        // R7: acknowledge before the interrupt exists must be ignored
        irq_ack = 1'b1;
        errs = 0;
        for (int s = 0; s < 3; s++) begin
            b_data[s] = ~word_of(s, 7);
        end
        b_valid = 3'b111;
        for (int k = 0; k < 256; k++) begin
            if (k % 9 == 4) begin
                b_valid[sel] = 1'b0;
                #1;
                if (mem_we) errs++;
                @(posedge clk);
                @(negedge clk);
                b_valid[sel] = 1'b1;
            end
            b_data[sel] = word_of(sel, k);
            #1;
            if (!mem_we || mem_addr != 20'h80000 + 20'(k) || mem_wdata != word_of(sel, k)
                || b_ready != exp_ready)
                errs++;
            @(posedge clk);
            @(negedge clk);
            irq_ack = 1'b0;
        end
        chk(errs == 0, "R4 writes follow handshake, address and data", errs, 0);
        #1;
        chk(b_ready == 3'b000 && !mem_we, "R5 no ready or write after 256 words",
            {b_ready, mem_we}, 0);
        chk(irq_par == !r.spi && irq_spi == r.spi, "R6 interrupt of booted peripheral",
            {irq_par, irq_spi}, {!r.spi, r.spi});
        chk(fetch_valid && fetch_addr == r.vec, "R6 R1 vector of latched source",
            fetch_addr, r.vec);
        repeat (5) @(posedge clk);
        @(negedge clk);
        kernel_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (!hold_done) kernel_done = 1'b0;
        #1;
        chk(irq_par == !r.spi && irq_spi == r.spi, "R7 interrupt held until acknowledge",
            {irq_par, irq_spi}, {!r.spi, r.spi});
        chk(fetch_addr == r.vec, "R8 early kernel_done ignored", fetch_addr, r.vec);
        irq_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk(!irq_par && !irq_spi, "R7 interrupt drops after acknowledge",
            {irq_par, irq_spi}, 0);
        chk(fetch_valid && fetch_addr == r.vec, "R8 vector held while kernel runs",
            fetch_addr, r.vec);
        if (hold_done) begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            #1;
            chk(fetch_addr == r.vec, "R8 held kernel_done level does not advance",
                fetch_addr, r.vec);
            kernel_done = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        kernel_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kernel_done = 1'b0;
        #1;
        chk(fetch_valid && fetch_addr == 20'h80005, "R8 run address after kernel_done",
            fetch_addr, 20'h80005);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(fetch_addr == 20'h80005 && !mem_we, "R8 run address is final",
            fetch_addr, 20'h80005);
    endtask

    initial begin
        for (int s = 0; s < 3; s++) b_data[s] = '0;
        for (int i = 0; i < 4; i++) begin
            run_row(ROWS[i], 1'b0);
        end
        // Corner: kernel_done level already high when the acknowledge lands
        run_row(ROWS[1], 1'b1);
        // Corner: reset in the middle of a load clears everything (R9)
        do_reset(2'b10);
        repeat (2) @(posedge clk);
        @(negedge clk);
        b_valid = 3'b111;
        repeat (20) @(posedge clk);
        do_reset(2'b00);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(b_ready == 3'b001 && !irq_par && !irq_spi && !fetch_valid,
            "R1 R9 new capture after mid-load reset", b_ready, 3'b001);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule